// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

The block gathers four maskable interrupt request lines and one non-maskable line. It hands the processor core a single request at a time. Each line has a fixed rank, a fixed IRQ number and a fixed vector address. The block raises its interrupt output only for the best eligible request whose rank is above every request the core is already servicing. In that way a more urgent source can interrupt a handler that is still running, while a source of equal or lower rank waits for that handler to finish.

Software enables or blocks each maskable line through a mask register. The non-maskable line bypasses the mask. The core takes a presented request with a one-cycle acknowledge pulse. That pulse moves the request from pending into service. The core closes a handler with a one-cycle end-of-interrupt pulse, which retires the most urgent request in service.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After a synchronous reset, int_o is low, no request is pending or in service, and mask_q reads 4'hF, so every maskable line is blocked.
- R2: Maskable line irq_req[0] has the top rank and irq_req[3] the lowest. Their IRQ numbers are 8, 7, 6 and 5, and their vectors are 0x14, 0x18, 0x1B and 0x1D, in the order irq_req[0] to irq_req[3].
- R3: nmi_req ignores the mask, outranks every maskable line, and is presented with IRQ number 9 and vector 0x10.
- R4: A mask bit of 1 blocks its line, and mask_q takes mask_wdata on the edge where mask_we is high. A request that arrives on a blocked line stays pending, is never presented while blocked, and is presented once its bit is cleared.
- R5: A rising request level is sampled through two flip-flops. int_o goes high at the fourth rising clock edge that sees the new level, provided nothing outranks the request.
- R6: While int_o is high and ack_i is low, int_o, irq_id_o and vec_o hold their values, even if a higher-ranked request arrives.
- R7: An acknowledge while int_o is high drops int_o at that edge. It clears the pending flag of the presented line and marks that line as in service.
- R8: A request is presented only if it outranks every line in service. A lower-ranked request waits until the end-of-interrupt that empties the higher ranks.
- R9: An end-of-interrupt clears the top-ranked in-service line. When acknowledge and end-of-interrupt arrive in the same cycle, the end-of-interrupt acts on the lines that were in service before that cycle.
- R10: Pending is set only by a rising edge of the request level. A level held high after its acknowledge does not raise a second request.
- R11: The non-maskable line has its own in-service flag. A new non-maskable request is not presented until the previous one has been ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_req | input | 1 | Non-maskable request level |
| irq_req | input | 4 | Maskable request levels, bit 0 ranked highest |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 4 | New mask value, 1 blocks a line |
| ack_i | input | 1 | Core acknowledge pulse |
| eoi_i | input | 1 | Core end-of-interrupt pulse |
| mask_q | output | 4 | Current mask register |
| int_o | output | 1 | Interrupt to the core |
| irq_id_o | output | 4 | IRQ number of the presented request, 0 when idle |
| vec_o | output | 8 | Vector address of the presented request, 0 when idle |

## Verification
Acknowledge and end-of-interrupt can fall in the same cycle. This happens when a nested request is accepted just as the core finishes an outer handler. The bench provokes the case by putting the lowest line in service, presenting a higher line, and pulsing ack_i and eoi_i together. It then judges the in-service set through the ports. The lowest line is re-raised, and it must be presented only after one further end-of-interrupt. Presentation hold against a late higher-ranked arrival is provoked separately and judged by sampling irq_id_o over several cycles.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int NMASK = 4;
  localparam int NLINE = NMASK + 1;
  localparam int IW    = $clog2(NLINE + 1);
  localparam int IDW   = 4;
  localparam int VW    = 8;

  typedef logic [IW-1:0] idx_t;

  // Rank index: 0 = non-maskable, 1..NMASK = irq_req[0..NMASK-1].
  function automatic logic [IDW-1:0] line_id(idx_t i);
    return IDW'(9 - int'(i));
  endfunction

  function automatic logic [VW-1:0] line_vec(idx_t i);
    case (i)
      idx_t'(0): return 8'h10;
      idx_t'(1): return 8'h14;
      idx_t'(2): return 8'h18;
      idx_t'(3): return 8'h1B;
      default:   return 8'h1D;
    endcase
  endfunction

  function automatic idx_t first_set(logic [NLINE-1:0] v);
    idx_t r = idx_t'(NLINE);
    for (int k = NLINE - 1; k >= 0; k--)
      if (v[k]) r = idx_t'(k);
    return r;
  endfunction
endpackage

// File: rtl/nic_sync.sv
module nic_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise
);
  for (genvar g = 0; g < W; g++) begin : g_line
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        s3 <= 1'b0;
      end else begin
        s1 <= d[g];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign rise[g] = s2 & ~s3;
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
(
  input  logic [NLINE-1:0] elig,
  input  logic [NLINE-1:0] isr,
  output logic             win_valid,
  output idx_t             win_idx,
  output idx_t             ceil_idx
);
  assign win_idx   = first_set(elig);
  assign ceil_idx  = first_set(isr);
  assign win_valid = (elig != '0) && (win_idx < ceil_idx);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             nmi_req,
  input  logic [NMASK-1:0] irq_req,
  input  logic             mask_we,
  input  logic [NMASK-1:0] mask_wdata,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic [NMASK-1:0] mask_q,
  output logic             int_o,
  output logic [IDW-1:0]   irq_id_o,
  output logic [VW-1:0]    vec_o
);
  logic [NLINE-1:0] rise, pend_q, isr_q, elig, ack_oh, eoi_oh;
  logic             pres_v, win_valid, cap_fire, ack_fire, eoi_fire;
  idx_t             pres_idx, win_idx, ceil_idx, cap_idx;

  nic_sync #(.W(NLINE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({irq_req, nmi_req}),
    .rise(rise)
  );

  assign elig = pend_q & {~mask_q, 1'b1};

  nic_arbiter u_arb (
    .elig     (elig),
    .isr      (isr_q),
    .win_valid(win_valid),
    .win_idx  (win_idx),
    .ceil_idx (ceil_idx)
  );

  assign cap_fire = !pres_v && win_valid;
  assign cap_idx  = win_idx;
  assign ack_fire = ack_i && pres_v;
  assign eoi_fire = eoi_i && (ceil_idx != idx_t'(NLINE));
  assign ack_oh   = ack_fire ? (NLINE'(1) << pres_idx) : '0;
  assign eoi_oh   = eoi_fire ? (NLINE'(1) << ceil_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '1;
      pend_q   <= '0;
      isr_q    <= '0;
      pres_v   <= 1'b0;
      pres_idx <= '0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      pend_q <= (pend_q & ~ack_oh) | rise;
      isr_q  <= (isr_q & ~eoi_oh) | ack_oh;
      if (ack_fire) begin
        pres_v <= 1'b0;
      end else if (cap_fire) begin
        pres_v   <= 1'b1;
        pres_idx <= cap_idx;
      end
    end
  end

  assign int_o    = pres_v;
  assign irq_id_o = pres_v ? line_id(pres_idx) : '0;
  assign vec_o    = pres_v ? line_vec(pres_idx) : '0;
endmodule

// File: rtl/nic_chk.sv
module nic_chk
  import nic_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ack_i,
  input logic             eoi_i,
  input logic [NMASK-1:0] mask_q,
  input logic             int_o,
  input logic [IDW-1:0]   irq_id_o,
  input logic [VW-1:0]    vec_o,
  input logic [NLINE-1:0] pend_q,
  input logic [NLINE-1:0] isr_q,
  input logic             cap_fire,
  input idx_t             cap_idx,
  input idx_t             pres_idx
);
  logic [NLINE-1:0] blocked, at_or_above;
  assign blocked     = {mask_q, 1'b0};
  assign at_or_above = (NLINE'(1) << pres_idx) | ((NLINE'(1) << pres_idx) - NLINE'(1));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    int_o && !ack_i |=> int_o && $stable(irq_id_o) && $stable(vec_o));

  a_r7_ack_moves: assert property (@(posedge clk) disable iff (rst)
    int_o && ack_i |=> !int_o && isr_q[$past(pres_idx)]);

  a_r4_no_blocked: assert property (@(posedge clk) disable iff (rst)
    cap_fire |-> !blocked[cap_idx]);

  a_r3_nmi_wins: assert property (@(posedge clk) disable iff (rst)
    cap_fire && pend_q[0] && !isr_q[0] |-> cap_idx == idx_t'(0));

  a_r8_above_service: assert property (@(posedge clk) disable iff (rst)
    int_o |-> (isr_q & at_or_above) == '0);

  a_r9_eoi_one: assert property (@(posedge clk) disable iff (rst)
    eoi_i && !ack_i && isr_q != '0 |=> $countones(isr_q) == $countones($past(isr_q)) - 1);

  a_r2_pairing: assert property (@(posedge clk) disable iff (rst)
    int_o |-> (irq_id_o == 4'd9 && vec_o == 8'h10) || (irq_id_o == 4'd8 && vec_o == 8'h14) ||
              (irq_id_o == 4'd7 && vec_o == 8'h18) || (irq_id_o == 4'd6 && vec_o == 8'h1B) ||
              (irq_id_o == 4'd5 && vec_o == 8'h1D));
endmodule

bind nest_irq_ctrl nic_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .ack_i   (ack_i),
  .eoi_i   (eoi_i),
  .mask_q  (mask_q),
  .int_o   (int_o),
  .irq_id_o(irq_id_o),
  .vec_o   (vec_o),
  .pend_q  (pend_q),
  .isr_q   (isr_q),
  .cap_fire(cap_fire),
  .cap_idx (cap_idx),
  .pres_idx(pres_idx)
);

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nmi_req = 1'b0;
  logic [3:0] irq_req = '0;
  logic       mask_we = 1'b0;
  logic [3:0] mask_wdata = '0;
  logic       ack_i = 1'b0;
  logic       eoi_i = 1'b0;
  logic [3:0] mask_q;
  logic       int_o;
  logic [3:0] irq_id_o;
  logic [7:0] vec_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nest_irq_ctrl u0 (
    .clk(clk), .rst(rst), .nmi_req(nmi_req), .irq_req(irq_req),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .ack_i(ack_i), .eoi_i(eoi_i),
    .mask_q(mask_q), .int_o(int_o), .irq_id_o(irq_id_o), .vec_o(vec_o)
  );

  function automatic logic [7:0] want_vec(int id);
    case (id)
      9: return 8'h10;
      8: return 8'h14;
      7: return 8'h18;
      6: return 8'h1B;
      5: return 8'h1D;
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_irq(string req, bit e, int id);
    checks++;
    if (int_o !== e || (e && (irq_id_o !== 4'(id) || vec_o !== want_vec(id)))) begin
      errors++;
      $display("FAIL %s: int=%0b id=%0d vec=%02h, expected int=%0b id=%0d vec=%02h",
               req, int_o, irq_id_o, vec_o, e, e ? id : 0, e ? want_vec(id) : 8'h00);
    end
  endtask

  task automatic expect_mask(string req, logic [3:0] m);
    checks++;
    if (mask_q !== m) begin
      errors++;
      $display("FAIL %s: mask_q=%h expected %h", req, mask_q, m);
    end
  endtask

  task automatic pulse_ack();  ack_i = 1'b1; step(1); ack_i = 1'b0; endtask
  task automatic pulse_eoi();  eoi_i = 1'b1; step(1); eoi_i = 1'b0; endtask
  task automatic write_mask(logic [3:0] m);
    mask_we = 1'b1; mask_wdata = m; step(1); mask_we = 1'b0;
  endtask

  task automatic t_reset();
    expect_irq("R1 reset int", 1'b0, 0);
    expect_mask("R1 reset mask", 4'hF);
  endtask

  task automatic t_mask();
    irq_req[2] = 1'b1; step(6);
    expect_irq("R4 blocked line hidden", 1'b0, 0);
    write_mask(4'h0);
    expect_mask("R4 mask write", 4'h0);
    step(1);
    expect_irq("R4 presented after unmask", 1'b1, 6);
    pulse_ack(); pulse_eoi();
    irq_req[2] = 1'b0; step(4);
  endtask

  task automatic t_latency();
    irq_req[3] = 1'b1; irq_req[1] = 1'b1;
    step(3);
    expect_irq("R5 not yet at edge 3", 1'b0, 0);
    step(1);
    expect_irq("R5 R2 higher of two at edge 4", 1'b1, 7);
    pulse_ack();
    expect_irq("R7 ack drops int", 1'b0, 0);
    step(3);
    expect_irq("R8 lower waits", 1'b0, 0);
    pulse_eoi(); step(1);
    expect_irq("R8 R2 lower after eoi", 1'b1, 5);
    pulse_ack(); pulse_eoi();
    irq_req = '0; step(4);
  endtask

  task automatic t_preempt();
    irq_req[3] = 1'b1; step(5);
    expect_irq("R2 lowest line", 1'b1, 5);
    pulse_ack();
    irq_req[0] = 1'b1; step(3);
    expect_irq("R5 preempt latency", 1'b0, 0);
    step(1);
    expect_irq("R8 preempt by top line", 1'b1, 8);
    pulse_ack(); pulse_eoi();
    irq_req[1] = 1'b1; step(4);
    expect_irq("R9 eoi retired top line only", 1'b1, 7);
    pulse_ack(); pulse_eoi(); pulse_eoi();
    step(5);
    expect_irq("R10 held levels do not re-request", 1'b0, 0);
    irq_req = '0; step(4);
  endtask

  task automatic t_stable();
    irq_req[2] = 1'b1; step(5);
    expect_irq("R2 third line", 1'b1, 6);
    irq_req[0] = 1'b1; step(6);
    expect_irq("R6 held against later arrival", 1'b1, 6);
    pulse_ack();
    expect_irq("R7 int low after ack", 1'b0, 0);
    step(1);
    expect_irq("R8 nested top line", 1'b1, 8);
    pulse_ack(); pulse_eoi(); pulse_eoi();
    irq_req = '0; step(4);
    expect_irq("R9 all ended idle", 1'b0, 0);
  endtask

  task automatic t_nmi();
    write_mask(4'hF);
    irq_req[0] = 1'b1; nmi_req = 1'b1; step(4);
    expect_irq("R3 nmi despite mask", 1'b1, 9);
    pulse_ack();
    nmi_req = 1'b0; step(3);
    nmi_req = 1'b1; step(6);
    expect_irq("R11 nmi does not nest", 1'b0, 0);
    pulse_eoi(); step(1);
    expect_irq("R11 second nmi after eoi", 1'b1, 9);
    pulse_ack(); pulse_eoi(); step(3);
    expect_irq("R4 masked line stays hidden", 1'b0, 0);
    write_mask(4'h0); step(1);
    expect_irq("R4 kept pending shown", 1'b1, 8);
    pulse_ack(); pulse_eoi();
    irq_req = '0; nmi_req = 1'b0; step(4);
  endtask

  task automatic t_ack_eoi();
    irq_req[3] = 1'b1; step(5);
    expect_irq("R9 setup low line", 1'b1, 5);
    pulse_ack();
    irq_req[1] = 1'b1; step(4);
    expect_irq("R9 nested line", 1'b1, 7);
    ack_i = 1'b1; eoi_i = 1'b1; step(1); ack_i = 1'b0; eoi_i = 1'b0;
    expect_irq("R9 R7 joint pulse drops int", 1'b0, 0);
    irq_req[3] = 1'b0; step(3);
    irq_req[3] = 1'b1; step(6);
    expect_irq("R9 new ack kept in service", 1'b0, 0);
    pulse_eoi(); step(1);
    expect_irq("R9 low line after last eoi", 1'b1, 5);
    pulse_ack(); pulse_eoi();
    irq_req = '0; step(4);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_mask();
    t_latency();
    t_preempt();
    t_stable();
    t_nmi();
    t_ack_eoi();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule